// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block arbitrates among up to 32 interrupt sources on behalf of a single processor core. Each source has an enable bit, a pending bit and an 8-bit priority register, all reached over a simple word-wide register bus. Only the top `PRIO_BITS` bits of each priority are stored. A programmable grouping setting splits them into an upper preemption field and a lower sub-priority field. Only the preemption field decides whether a new interrupt may interrupt a running handler.

The controller keeps a stack of the priorities of the handlers that are in progress. Each cycle it picks the most urgent pending source that is enabled and not masked. It raises `irq_req` with that source's index when the source is allowed to run. It is allowed to run when no handler is active, or when its preemption value is strictly below that of the innermost active handler. The core accepts with `irq_take` and reports handler completion with `irq_eoh`. A global disable bit and a priority threshold give software two ways to hold requests off.

Register map (word addresses on `bus_addr`): 0 = enable bits (bit i = source i). 1 = pending, where a write of ones sets bits. 2 = pending, where a write of ones clears bits. Addresses 1 and 2 both read the pending bits. 3 = control: bit 0 global disable, bits 10:8 grouping, bits 23:16 threshold. 0x40+n = priority of source n, held in bits 7:0.

Top module: `nest_irq_ctrl`

## Requirements
- R1: A source whose enable bit (address 0, bit i) is clear is never presented on `irq_req`/`irq_id`, whatever its pending state.
- R2: A pending bit can be set while its source is disabled. Writing the enable bit then raises the request on the next clock after the write has taken effect.
- R3: Writes to a priority register (0x40+n) keep bits 7 down to 8-PRIO_BITS. The unimplemented low bits read back as zero. A lower value is more urgent, and the presented source carries the lowest stored value among eligible sources.
- R4: Control bits 10:8 give the number of implemented priority bits that form the preemption field, counted from the top. A value above PRIO_BITS is stored as PRIO_BITS and reads back so.
- R5: While a handler is active, a request is raised only if the candidate's preemption field is strictly lower than that of the innermost active priority. A lower sub-priority alone never preempts, and with grouping 0 no nesting happens.
- R6: When the stored priorities of eligible sources are equal, the lowest source index is presented.
- R7: While control bit 0 is set, `irq_req` stays low.
- R8: A nonzero threshold (control bits 23:16, top PRIO_BITS bits kept) masks every source whose priority is greater than or equal to it. More urgent sources are unaffected.
- R9: A pending bit is set by a 0-to-1 change of its `src_irq` line, by a one written at address 1, and cleared by a one written at address 2. A set in the same cycle as a clear wins.
- R10: `irq_take` while `irq_req` is high clears the presented source's pending bit and pushes its priority on the active stack (`act_depth` +1, `act_prio` = that priority). `irq_req` is low on the next cycle. `irq_take` with `irq_req` low has no effect.
- R11: `irq_eoh` pops the stack and restores the previous `act_prio`. It is ignored when the stack is empty. When it arrives together with an accepted take, the new priority replaces the top entry.
- R12: `irq_req` and `irq_id` are registered. They reflect the state one clock after any change of enable, pending, priority or mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| src_irq | input | NUM_SRC | interrupt request lines, one per source |
| bus_wr | input | 1 | register write strobe |
| bus_addr | input | 7 | register word address |
| bus_wdata | input | 32 | register write data |
| bus_rdata | output | 32 | register read data for `bus_addr` |
| irq_req | output | 1 | an interrupt is offered to the core |
| irq_id | output | $clog2(NUM_SRC) | index of the offered source |
| irq_take | input | 1 | core accepts the offered interrupt |
| irq_eoh | input | 1 | core finished the innermost handler |
| act_depth | output | $clog2(2**PRIO_BITS+1) | number of active handlers |
| act_prio | output | 8 | priority of the innermost active handler, 0 when none |

## Verification
Directed phases first try a single source pended while disabled and then enabled. They then try equal priorities on several lines, which separates index tie-breaking from priority order. Nested takes under full preemption grouping show the strictly-lower rule. The same priority values under one-bit grouping and zero-bit grouping show that sub-priority alone and the zero grouping never nest. Threshold and global-disable phases pend urgent and non-urgent sources together, to tell masking of the less urgent set from masking of all. A long pseudo-random phase mixes line edges, register writes, takes and end-of-handler pulses, simultaneous take and end included, against the reference model.

// File: rtl/nirq_pkg.sv
package nirq_pkg;
   localparam int ADDR_W = 7;
   localparam logic [ADDR_W-1:0] A_ENABLE  = 7'h00;
   localparam logic [ADDR_W-1:0] A_PSET    = 7'h01;
   localparam logic [ADDR_W-1:0] A_PCLR    = 7'h02;
   localparam logic [ADDR_W-1:0] A_CONTROL = 7'h03;
   localparam int CTL_GDIS   = 0;
   localparam int CTL_GRP_LO = 8;
   localparam int CTL_THR_HI = 23;
endpackage

// File: rtl/nirq_regs.sv
module nirq_regs
   import nirq_pkg::*;
#(
   parameter int N  = 32,
   parameter int PB = 3,
   localparam int IW = $clog2(N)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [N-1:0]         src_irq,
   input  logic                 bus_wr,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [31:0]          bus_wdata,
   output logic [31:0]          bus_rdata,
   input  logic                 take_fire,
   input  logic [IW-1:0]        take_id,
   output logic [N-1:0]         en_q,
   output logic [N-1:0]         pend_q,
   output logic [N-1:0][PB-1:0] prio_q,
   output logic                 gdis_q,
   output logic [2:0]           grp_q,
   output logic [PB-1:0]        thr_q
);
   localparam int LOWZ = 8 - PB;

   logic [N-1:0] src_d;
   logic [5:0]   slot;
   logic         prio_hit;
   logic         wr_set, wr_clr, wr_en, wr_ctl;
   logic [2:0]   grp_in;

   assign slot     = bus_addr[5:0];
   assign prio_hit = bus_addr[6] && (int'(slot) < N);
   assign wr_en    = bus_wr && (bus_addr == A_ENABLE);
   assign wr_set   = bus_wr && (bus_addr == A_PSET);
   assign wr_clr   = bus_wr && (bus_addr == A_PCLR);
   assign wr_ctl   = bus_wr && (bus_addr == A_CONTROL);
   assign grp_in   = bus_wdata[CTL_GRP_LO+2:CTL_GRP_LO];

   for (genvar i = 0; i < N; i++) begin : g_src
      logic set_i, clr_i;
      assign set_i = (src_irq[i] & ~src_d[i]) | (wr_set & bus_wdata[i]);
      assign clr_i = (wr_clr & bus_wdata[i]) | (take_fire && (take_id == IW'(i)));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            src_d[i]  <= 1'b0;
            pend_q[i] <= 1'b0;
            prio_q[i] <= '0;
         end else begin
            src_d[i]  <= src_irq[i];
            pend_q[i] <= (pend_q[i] & ~clr_i) | set_i;
            if (bus_wr && prio_hit && (slot == 6'(i)))
               prio_q[i] <= bus_wdata[7:LOWZ];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         gdis_q <= 1'b0;
         grp_q  <= '0;
         thr_q  <= '0;
      end else begin
         if (wr_en) en_q <= bus_wdata[N-1:0];
         if (wr_ctl) begin
            gdis_q <= bus_wdata[CTL_GDIS];
            grp_q  <= (int'(grp_in) > PB) ? 3'(PB) : grp_in;
            thr_q  <= bus_wdata[CTL_THR_HI:CTL_THR_HI+1-PB];
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (prio_hit) begin
         bus_rdata = {24'b0, prio_q[slot[IW-1:0]], {LOWZ{1'b0}}};
      end else begin
         case (bus_addr)
            A_ENABLE:  bus_rdata = 32'(en_q);
            A_PSET:    bus_rdata = 32'(pend_q);
            A_PCLR:    bus_rdata = 32'(pend_q);
            A_CONTROL: bus_rdata = {8'b0, thr_q, {LOWZ{1'b0}}, 5'b0, grp_q, 7'b0, gdis_q};
            default:   bus_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/nirq_arbiter.sv
module nirq_arbiter #(
   parameter int N  = 32,
   parameter int PB = 3,
   localparam int IW = $clog2(N)
) (
   input  logic [N-1:0]         pend,
   input  logic [N-1:0]         en,
   input  logic [N-1:0][PB-1:0] prio,
   input  logic                 gdis,
   input  logic [2:0]           grp,
   input  logic [PB-1:0]        thr,
   input  logic                 act_nz,
   input  logic [PB-1:0]        act_top,
   output logic                 want,
   output logic [IW-1:0]        best_id
);
   logic          found;
   logic [PB-1:0] best_p;
   logic [N-1:0]  elig;

   function automatic logic [PB-1:0] pre_of(input logic [PB-1:0] p, input logic [2:0] g);
      return p >> (PB - int'(g));
   endfunction

   for (genvar i = 0; i < N; i++) begin : g_elig
      assign elig[i] = pend[i] & en[i] & ~((thr != '0) && (prio[i] >= thr));
   end

   always_comb begin
      found   = 1'b0;
      best_p  = '1;
      best_id = '0;
      for (int i = 0; i < N; i++) begin
         if (elig[i] && (!found || (prio[i] < best_p))) begin
            found   = 1'b1;
            best_p  = prio[i];
            best_id = IW'(i);
         end
      end
      want = found && !gdis && (!act_nz || (pre_of(best_p, grp) < pre_of(act_top, grp)));
   end
endmodule

// File: rtl/nirq_stack.sv
module nirq_stack #(
   parameter int PB    = 3,
   parameter int DEPTH = 8,
   localparam int AW = $clog2(DEPTH),
   localparam int DW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic          pop,
   input  logic [PB-1:0] din,
   output logic [DW-1:0] depth,
   output logic [PB-1:0] top
);
   logic [PB-1:0] mem [DEPTH];
   logic [DW-1:0] spm1;
   logic          eff_pop, eff_push;

   assign spm1     = depth - 1'b1;
   assign eff_pop  = pop && (depth != '0);
   assign eff_push = push && ((depth != DW'(DEPTH)) || eff_pop);
   assign top      = (depth == '0) ? '0 : mem[spm1[AW-1:0]];

   always_ff @(posedge clk) begin
      if (eff_push && eff_pop)
         mem[spm1[AW-1:0]] <= din;
      else if (eff_push)
         mem[depth[AW-1:0]] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         depth <= '0;
      else if (eff_push && !eff_pop)
         depth <= depth + 1'b1;
      else if (eff_pop && !eff_push)
         depth <= spm1;
   end
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
   import nirq_pkg::*;
#(
   parameter int NUM_SRC   = 32,
   parameter int PRIO_BITS = 3,
   localparam int IW    = $clog2(NUM_SRC),
   localparam int DEPTH = 1 << PRIO_BITS,
   localparam int DW    = $clog2(DEPTH + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_irq,
   input  logic               bus_wr,
   input  logic [6:0]         bus_addr,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   output logic               irq_req,
   output logic [IW-1:0]      irq_id,
   input  logic               irq_take,
   input  logic               irq_eoh,
   output logic [DW-1:0]      act_depth,
   output logic [7:0]         act_prio
);
   if (NUM_SRC < 2 || NUM_SRC > 32) begin : g_bad_num
      $error("nest_irq_ctrl: NUM_SRC must lie in 2..32");
   end
   if (PRIO_BITS < 3 || PRIO_BITS > 4) begin : g_bad_prio
      $error("nest_irq_ctrl: PRIO_BITS must be 3 or 4");
   end

   logic [NUM_SRC-1:0]                en_q, pend_q;
   logic [NUM_SRC-1:0][PRIO_BITS-1:0] prio_q;
   logic                              gdis_q;
   logic [2:0]                        grp_q;
   logic [PRIO_BITS-1:0]              thr_q, top_p;
   logic                              take_fire, want;
   logic [IW-1:0]                     best_id;

   assign take_fire = irq_take && irq_req;

   nirq_regs #(.N(NUM_SRC), .PB(PRIO_BITS)) u_regs (
      .clk, .rst_n, .src_irq, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
      .take_fire, .take_id(irq_id), .en_q, .pend_q, .prio_q,
      .gdis_q, .grp_q, .thr_q
   );

   nirq_arbiter #(.N(NUM_SRC), .PB(PRIO_BITS)) u_arb (
      .pend(pend_q), .en(en_q), .prio(prio_q), .gdis(gdis_q), .grp(grp_q),
      .thr(thr_q), .act_nz(act_depth != '0), .act_top(top_p),
      .want, .best_id
   );

   nirq_stack #(.PB(PRIO_BITS), .DEPTH(DEPTH)) u_stk (
      .clk, .rst_n, .push(take_fire), .pop(irq_eoh),
      .din(prio_q[irq_id]), .depth(act_depth), .top(top_p)
   );

   assign act_prio = {top_p, {(8-PRIO_BITS){1'b0}}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_req <= 1'b0;
         irq_id  <= '0;
      end else begin
         irq_req <= want && !take_fire;
         irq_id  <= best_id;
      end
   end
endmodule

// File: rtl/nirq_checker.sv
module nirq_checker #(
   parameter int N     = 32,
   parameter int IW    = 5,
   parameter int DW    = 4,
   parameter int DEPTH = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          irq_req,
   input logic [IW-1:0] irq_id,
   input logic          irq_take,
   input logic          irq_eoh,
   input logic [DW-1:0] act_depth,
   input logic [N-1:0]  en_q,
   input logic          gdis_q
);
   logic [N-1:0] en_d;
   logic         gdis_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_d   <= '0;
         gdis_d <= 1'b0;
      end else begin
         en_d   <= en_q;
         gdis_d <= gdis_q;
      end
   end

   assert_disabled_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> en_d[irq_id]);

   assert_gdis_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> !gdis_d);

   assert_take_drops_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_take && irq_req) |=> !irq_req);

   assert_take_push_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_take && irq_req && !irq_eoh) |=> (act_depth == $past(act_depth) + 1'b1));

   assert_eoh_pop_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_eoh && !irq_take && act_depth != '0) |=> (act_depth == $past(act_depth) - 1'b1));

   assert_depth_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      int'(act_depth) <= DEPTH);
endmodule

bind nest_irq_ctrl nirq_checker #(.N(NUM_SRC), .IW(IW), .DW(DW), .DEPTH(DEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_id(irq_id),
   .irq_take(irq_take), .irq_eoh(irq_eoh), .act_depth(act_depth),
   .en_q(en_q), .gdis_q(gdis_q)
);

// File: tb/sim_nest_irq_ctrl.sv
module sim_nest_irq_ctrl;
   localparam int N   = 32;
   localparam int PB  = 3;
   localparam int IW  = $clog2(N);
   localparam int DW  = $clog2((1 << PB) + 1);
   localparam time CLK_PERIOD = 10ns;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  src_irq = '0;
   logic          bus_wr = 1'b0;
   logic [6:0]    bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic          irq_req;
   logic [IW-1:0] irq_id;
   logic          irq_take = 1'b0;
   logic          irq_eoh = 1'b0;
   logic [DW-1:0] act_depth;
   logic [7:0]    act_prio;

   nest_irq_ctrl #(.NUM_SRC(N), .PRIO_BITS(PB)) u0 (
      .clk, .rst_n, .src_irq, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
      .irq_req, .irq_id, .irq_take, .irq_eoh, .act_depth, .act_prio
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int    checks = 0;
   int    errors = 0;
   int    cycles = 0;
   string cur_req = "R12";

   // reference model state
   bit m_en [N];
   bit m_pend [N];
   bit m_srcd [N];
   int m_prio [N];
   bit m_gdis;
   int m_grp, m_thr;
   int stk [$];
   bit m_req;
   int m_id;

   task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at cycle %0d", r, act, exp, cycles);
      end
   endtask

   function automatic int pre(int p);
      return p >> (PB - m_grp);
   endfunction

   function automatic logic [31:0] m_read(logic [6:0] a);
      logic [31:0] v = '0;
      if (a[6] && int'(a[5:0]) < N) v = 32'(m_prio[a[5:0]] << (8 - PB));
      else if (a == 7'h00) for (int i = 0; i < N; i++) v[i] = m_en[i];
      else if (a == 7'h01 || a == 7'h02) for (int i = 0; i < N; i++) v[i] = m_pend[i];
      else if (a == 7'h03) v = 32'((m_thr << (24 - PB)) | (m_grp << 8) | int'(m_gdis));
      return v;
   endfunction

   task automatic model_edge();
      int  best = -1;
      bit  take_f = irq_take && m_req;
      bit  nreq;
      int  g;
      for (int i = 0; i < N; i++)
         if (m_pend[i] && m_en[i] && !(m_thr != 0 && m_prio[i] >= m_thr))
            if (best < 0 || m_prio[i] < m_prio[best]) best = i;
      nreq = !take_f && !m_gdis && best >= 0 &&
             (stk.size() == 0 || pre(m_prio[best]) < pre(stk[$]));
      if (irq_eoh && stk.size() > 0) void'(stk.pop_back());
      if (take_f) stk.push_back(m_prio[m_id]);
      for (int i = 0; i < N; i++) begin
         bit s = (src_irq[i] && !m_srcd[i]) || (bus_wr && bus_addr == 7'h01 && bus_wdata[i]);
         bit c = (bus_wr && bus_addr == 7'h02 && bus_wdata[i]) || (take_f && m_id == i);
         m_pend[i] = (m_pend[i] && !c) || s;
         m_srcd[i] = src_irq[i];
      end
      if (bus_wr) begin
         if (bus_addr == 7'h00) for (int i = 0; i < N; i++) m_en[i] = bus_wdata[i];
         if (bus_addr == 7'h03) begin
            m_gdis = bus_wdata[0];
            g = int'(bus_wdata[10:8]);
            m_grp = (g > PB) ? PB : g;
            m_thr = int'(bus_wdata[23:16]) >> (8 - PB);
         end
         if (bus_addr[6] && int'(bus_addr[5:0]) < N)
            m_prio[bus_addr[5:0]] = int'(bus_wdata[7:0]) >> (8 - PB);
      end
      m_req = nreq;
      if (best >= 0) m_id = best;
   endtask

   task automatic compare();
      chk(cur_req, 32'(irq_req), 32'(m_req));
      if (m_req) chk(cur_req, 32'(irq_id), 32'(m_id));
      chk(cur_req, 32'(act_depth), 32'(stk.size()));
      chk(cur_req, 32'(act_prio), (stk.size() == 0) ? 32'd0 : 32'(stk[$] << (8 - PB)));
      chk(cur_req, bus_rdata, m_read(bus_addr));
   endtask

   task automatic tick();
      @(posedge clk);
      if (rst_n) model_edge();
      @(negedge clk);
      cycles++;
      if (rst_n) compare();
   endtask

   task automatic idle(int n);
      for (int k = 0; k < n; k++) tick();
   endtask

   task automatic wr(logic [6:0] a, logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      tick();
      bus_wr = 1'b0;
   endtask

   task automatic pulse(int i);
      src_irq[i] = 1'b1; tick();
      src_irq[i] = 1'b0; tick();
   endtask

   task automatic take();
      irq_take = 1'b1; tick(); irq_take = 1'b0;
   endtask

   task automatic eoh();
      irq_eoh = 1'b1; tick(); irq_eoh = 1'b0;
   endtask

   always @(posedge clk) begin
      if (cycles > 150000) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=<150000", cycles);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < N; i++) begin
         m_en[i] = 0; m_pend[i] = 0; m_srcd[i] = 0; m_prio[i] = 0;
      end
      m_gdis = 0; m_grp = 0; m_thr = 0; m_req = 0; m_id = 0;
      idle(3);
      rst_n = 1'b1;
      tick();
      chk("R12", 32'(irq_req), 32'd0);
      chk("R10", 32'(act_depth), 32'd0);

      cur_req = "R3";
      wr(7'h43, 32'h40); wr(7'h45, 32'h80); wr(7'h47, 32'h80);
      wr(7'h49, 32'h20); wr(7'h4C, 32'hC0); wr(7'h54, 32'hFF);
      bus_addr = 7'h54; tick();
      chk("R3", bus_rdata, 32'hE0);

      cur_req = "R4";
      wr(7'h03, 32'h0000_0700);
      bus_addr = 7'h03; tick();
      chk("R4", bus_rdata, 32'h0000_0300);

      cur_req = "R1";
      pulse(5); idle(2);
      chk("R1", 32'(irq_req), 32'd0);
      cur_req = "R9";
      bus_addr = 7'h01; tick();
      chk("R9", bus_rdata & 32'h20, 32'h20);

      cur_req = "R2";
      wr(7'h00, 32'hFFFF_FFFF); idle(1);
      chk("R2", 32'(irq_req), 32'd1);
      chk("R2", 32'(irq_id), 32'd5);

      cur_req = "R6";
      pulse(7); idle(1);
      chk("R6", 32'(irq_id), 32'd5);

      cur_req = "R10";
      take();
      chk("R10", 32'(irq_req), 32'd0);
      chk("R10", 32'(act_prio), 32'h80);
      take();
      chk("R10", 32'(act_depth), 32'd1);

      cur_req = "R5";
      pulse(12); pulse(3); idle(1);
      chk("R5", 32'(irq_id), 32'd3);
      take(); idle(1);
      chk("R5", 32'(act_depth), 32'd2);

      cur_req = "R11";
      eoh();
      chk("R11", 32'(act_prio), 32'h80);
      eoh(); idle(1);
      chk("R11", 32'(irq_id), 32'd7);
      eoh(); idle(1);

      cur_req = "R5";
      wr(7'h02, 32'hFFFF_FFFF);
      wr(7'h03, 32'h0000_0100);
      pulse(12); take(); idle(1);
      pulse(5); idle(2);
      chk("R5", 32'(irq_req), 32'd0);
      pulse(9); idle(1);
      chk("R5", 32'(irq_id), 32'd9);
      take(); eoh(); eoh(); idle(2);
      wr(7'h02, 32'hFFFF_FFFF);
      wr(7'h03, 32'h0000_0000);
      pulse(12); take(); pulse(9); idle(2);
      chk("R5", 32'(irq_req), 32'd0);
      eoh(); idle(2);

      cur_req = "R8";
      wr(7'h02, 32'hFFFF_FFFF);
      wr(7'h03, 32'h0060_0300);
      pulse(5); pulse(12); idle(2);
      chk("R8", 32'(irq_req), 32'd0);
      pulse(3); idle(1);
      chk("R8", 32'(irq_id), 32'd3);
      take(); eoh(); idle(2);

      cur_req = "R7";
      wr(7'h03, 32'h0000_0301);
      idle(3);
      chk("R7", 32'(irq_req), 32'd0);
      wr(7'h03, 32'h0000_0300); idle(2);

      cur_req = "R9";
      wr(7'h02, 32'hFFFF_FFFF);
      wr(7'h01, 32'h0000_0200); idle(1);
      chk("R9", 32'(irq_id), 32'd9);
      bus_wr = 1'b1; bus_addr = 7'h02; bus_wdata = 32'h200;
      src_irq[9] = 1'b1; tick();
      bus_wr = 1'b0; src_irq[9] = 1'b0;
      bus_addr = 7'h01; tick();
      chk("R9", bus_rdata & 32'h200, 32'h200);

      cur_req = "R11";
      take(); pulse(3); idle(1);
      irq_take = 1'b1; irq_eoh = 1'b1; tick();
      irq_take = 1'b0; irq_eoh = 1'b0; idle(1);
      eoh(); eoh(); idle(1);

      cur_req = "R12";
      for (int k = 0; k < 3000; k++) begin
         int r = int'($urandom_range(0, 99));
         src_irq = src_irq ^ ((r < 30) ? (32'h1 << $urandom_range(0, N-1)) : 32'h0);
         irq_take = ($urandom_range(0, 3) == 0);
         irq_eoh  = ($urandom_range(0, 5) == 0);
         if (r >= 90) begin
            bus_wr = 1'b1;
            case (r % 5)
               0: begin bus_addr = 7'h00; bus_wdata = $urandom; end
               1: begin bus_addr = 7'h01; bus_wdata = $urandom & $urandom; end
               2: begin bus_addr = 7'h02; bus_wdata = $urandom; end
               3: begin bus_addr = 7'h03; bus_wdata = $urandom & 32'h00FF_0700; end
               default: begin bus_addr = 7'(7'h40 + $urandom_range(0, N-1)); bus_wdata = $urandom; end
            endcase
         end else begin
            bus_wr = 1'b0;
            bus_addr = 7'($urandom_range(0, 7'h5F));
         end
         tick();
      end
      bus_wr = 1'b0; irq_take = 1'b0; irq_eoh = 1'b0;
      idle(2);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule